// File: doc/BRIEF.md
# Break-Aware Two-Step Status Flag Bank

This block holds a bank of status flags for a peripheral. Hardware events raise the flags. Software lowers them with a two-step sequence. The first step is a read of the status register that sees the flag at 1, which arms that flag for clearing. The second step is any read or write of the data register, which lowers every armed flag. The flags drive the peripheral's interrupt and status logic. Software sees them through the status register.

A debug break input interacts with a clear-enable input. While the break is active and clear-enable is 0, the bank is frozen. In that state, status reads and data accesses neither arm nor clear anything, and a flag armed before the break stays armed until the break ends. With clear-enable at 1, the sequence works during the break as it does outside it, and anything cleared stays cleared afterwards. Clear-enable is meant to come from a control bit whose reset value is 0, so flags are protected by default.

Each flag is a three-state machine. `FL_CLEAR` means the flag is 0. `FL_RAISED` means the flag is 1 and not armed. `FL_ARMED` means the flag is 1 and armed. The transitions are:

- `FL_CLEAR`→`FL_RAISED` on a set event.
- `FL_RAISED`→`FL_ARMED` on an effective status read.
- `FL_ARMED`→`FL_CLEAR` on an effective data access with no set event in the same cycle.
- `FL_ARMED`→`FL_RAISED` on an effective data access together with a set event.

Every other combination holds the state. An access is effective when it is not frozen.

Top module: `sflag_bank`

## Requirements
- R1: After a synchronous active-low reset, all flags are 0 and none is armed, so a following data access clears nothing.
- R2: A 1 on `hw_set[i]` makes `flags[i]` 1 from the next cycle. A read of the status register (address 0) returns bit i = flag i on `bus_rdata` in the same cycle; other accesses return 0.
- R3: A status read that sees a flag at 1 arms it. A later read or write of the data register (address 1) lowers every armed flag in the following cycle.
- R4: A data access lowers no flag that was not armed by an earlier status read, including flags raised after that read.
- R5: A set event in the same cycle as a clearing data access wins. The flag stays 1 and is disarmed, so the next data access leaves it at 1.
- R6: While `brk_active`=1 and `brk_clr_en`=0, status reads arm nothing and data accesses lower nothing.
- R7: A flag armed before a frozen break stays armed through it. The first data access after the break ends lowers it.
- R8: With `brk_clr_en`=1, the two-step sequence lowers flags during a break, and they stay 0 after the break ends.
- R9: While frozen, a set event still raises a flag that was 0.
- R10: Accesses to addresses 2 and 3 neither arm nor lower any flag.
- R11: A set event on an already armed flag without a data access keeps it armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 status, 1 data) |
| bus_rdata | output | NUM_FLAGS | Status read data |
| hw_set | input | NUM_FLAGS | Per-flag set events from the peripheral |
| brk_active | input | 1 | Debug break state is active |
| brk_clr_en | input | 1 | Allow clearing while in break |
| flags | output | NUM_FLAGS | Current flag values |

## Verification
The hardest case to reach from the ports is a flag left armed across a frozen break. The bench raises flags, performs the status read, and then asserts the break with clear-enable at 0. It then issues status reads, data reads and data writes, and the flags must not move. After the break is released, one data access must lower exactly the flags armed before the break. Two sweeps cover every pair of set patterns. The first places set events in the clearing cycle. The second places them between the two steps. The expected flags are computed as bit masks.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
    typedef enum logic [1:0] {
        FL_CLEAR  = 2'd0,
        FL_RAISED = 2'd1,
        FL_ARMED  = 2'd2
    } flag_state_t;
endpackage

// File: rtl/sflag_access_dec.sv
module sflag_access_dec #(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              brk_active,
    input  logic              brk_clr_en,
    output logic              stat_sel_o,
    output logic              arm_o,
    output logic              clr_o,
    output logic              frozen_o
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

    logic hit_stat;
    logic hit_data;

    always_comb begin
        hit_stat   = (bus_addr == STAT_A);
        hit_data   = (bus_addr == DATA_A);
        frozen_o   = brk_active & ~brk_clr_en;
        stat_sel_o = bus_rd & hit_stat;
        arm_o      = stat_sel_o & ~frozen_o;
        clr_o      = (bus_rd | bus_wr) & hit_data & ~frozen_o;
    end

    // a frozen cycle never produces an effective access
    AST_FROZEN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && !brk_clr_en) |-> !(arm_o || clr_o)); // R6
    AST_ODD_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != STAT_A && bus_addr != DATA_A) |-> !(arm_o || clr_o)); // R10
endmodule

// File: rtl/sflag_cell.sv
module sflag_cell
    import sflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set_i,
    input  logic arm_i,
    input  logic clr_i,
    input  logic frozen_i,
    output logic flag_o,
    output logic armed_o
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: begin
                if (hw_set_i) state_d = FL_RAISED;
            end
            FL_RAISED: begin
                if (arm_i) state_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (clr_i) state_d = hw_set_i ? FL_RAISED : FL_CLEAR;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o  = (state_q != FL_CLEAR);
        armed_o = (state_q == FL_ARMED);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set_i |=> flag_o); // R5
    AST_UNARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !armed_o) |=> flag_o); // R4
    AST_ARMED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && clr_i && !hw_set_i) |=> !flag_o); // R3
    AST_FROZEN_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_i && flag_o) |=> flag_o); // R6
    AST_FROZEN_ARM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_i && armed_o) |=> armed_o); // R7
    AST_SET_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && hw_set_i && !clr_i) |=> armed_o); // R11
endmodule

// File: rtl/sflag_bank.sv
module sflag_bank #(
    parameter int NUM_FLAGS = 4,
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_FLAGS-1:0] bus_rdata,
    input  logic [NUM_FLAGS-1:0] hw_set,
    input  logic                 brk_active,
    input  logic                 brk_clr_en,
    output logic [NUM_FLAGS-1:0] flags
);
    logic                 stat_sel;
    logic                 arm;
    logic                 clr;
    logic                 frozen;
    logic [NUM_FLAGS-1:0] armed;

    sflag_access_dec #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .brk_active(brk_active),
        .brk_clr_en(brk_clr_en),
        .stat_sel_o(stat_sel),
        .arm_o     (arm),
        .clr_o     (clr),
        .frozen_o  (frozen)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cell
        sflag_cell cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_set_i(hw_set[g]),
            .arm_i   (arm),
            .clr_i   (clr),
            .frozen_i(frozen),
            .flag_o  (flags[g]),
            .armed_o (armed[g])
        );
    end

    always_comb begin
        bus_rdata = stat_sel ? flags : '0;
    end

    // an effective data access leaves no flag armed unless set in that cycle
    AST_CLR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((armed & ~$past(hw_set)) == '0)); // R3
    AST_NO_STRAY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set == '0) |=> ((flags & ~$past(flags)) == '0)); // R2
endmodule

// File: tb/sflag_bank_tb_top.sv
module sflag_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [3:0] hw_set = 4'd0;
    logic       brk_active = 1'b0;
    logic       brk_clr_en = 1'b0;
    logic [3:0] bus_rdata;
    logic [3:0] flags;
    logic [3:0] rd_cap;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    sflag_bank #(.NUM_FLAGS(4), .ADDR_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata), .hw_set(hw_set),
        .brk_active(brk_active), .brk_clr_en(brk_clr_en), .flags(flags)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one bus cycle driven at a falling edge; outputs are read at the next falling edge
    task automatic step(input logic rd, input logic wr, input logic [1:0] a, input logic [3:0] s);
        bus_rd = rd; bus_wr = wr; bus_addr = a; hw_set = s;
        #1 rd_cap = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; hw_set = 4'd0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; brk_active = 1'b0; brk_clr_en = 1'b0;
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state and no armed flag
        check("R1 flags", flags, 4'b0000);
        step(1, 0, 0, 0);
        check("R1 rdata", rd_cap, 4'b0000);
        step(0, 1, 1, 0);
        check("R1 data access", flags, 4'b0000);

        // sweep: set p, arm, data access with set q in same cycle (R2 R3 R5)
        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 16; q++) begin
                do_reset();
                step(0, 0, 0, 4'(p));
                check("R2 set", flags, 4'(p));
                step(1, 0, 0, 0);
                check("R2 rdata", rd_cap, 4'(p));
                step(q[0], ~q[0], 1, 4'(q));
                check("R3 R5 clear with set", flags, 4'(q));
                step(1, 0, 1, 0);
                check("R5 disarmed", flags, 4'(q));
            end
        end

        // sweep: set p, arm, set r between steps, then clear (R4 R11)
        for (int p = 0; p < 16; p++) begin
            for (int r = 0; r < 16; r++) begin
                do_reset();
                step(0, 0, 0, 4'(p));
                step(1, 0, 0, 0);
                step(0, 0, 0, 4'(r));
                step(0, 1, 1, 0);
                check("R4 R11 partial clear", flags, 4'(r & ~p));
            end
        end

        // R6 R9 frozen break: no arm, no clear, set still works
        do_reset();
        step(0, 0, 0, 4'b0011);
        brk_active = 1'b1; brk_clr_en = 1'b0;
        step(0, 0, 0, 4'b1100);
        check("R9 set while frozen", flags, 4'b1111);
        step(1, 0, 0, 0);
        check("R6 read while frozen", rd_cap, 4'b1111);
        step(1, 0, 1, 0);
        step(0, 1, 1, 0);
        check("R6 no clear while frozen", flags, 4'b1111);
        brk_active = 1'b0;
        step(0, 1, 1, 0);
        check("R6 no arm while frozen", flags, 4'b1111);

        // R7 armed before frozen break
        do_reset();
        step(0, 0, 0, 4'b0101);
        step(1, 0, 0, 0);
        brk_active = 1'b1;
        step(0, 1, 1, 0);
        step(1, 0, 1, 0);
        step(1, 0, 0, 0);
        check("R7 held in break", flags, 4'b0101);
        brk_active = 1'b0;
        step(0, 0, 0, 0);
        check("R7 held after break", flags, 4'b0101);
        step(1, 0, 1, 0);
        check("R7 cleared after break", flags, 4'b0000);

        // R8 clear enabled during break
        do_reset();
        step(0, 0, 0, 4'b0011);
        brk_active = 1'b1; brk_clr_en = 1'b1;
        step(1, 0, 0, 0);
        step(0, 1, 1, 0);
        check("R8 cleared in break", flags, 4'b0000);
        brk_active = 1'b0; brk_clr_en = 1'b0;
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        check("R8 stays cleared", flags, 4'b0000);

        // R10 other addresses neither arm nor clear
        do_reset();
        step(0, 0, 0, 4'b1111);
        step(1, 0, 2, 0);
        step(1, 0, 3, 0);
        check("R10 rdata other", rd_cap, 4'b0000);
        step(0, 1, 1, 0);
        check("R10 no arm", flags, 4'b1111);
        step(1, 0, 0, 0);
        step(0, 1, 2, 0);
        step(1, 0, 3, 0);
        check("R10 no clear", flags, 4'b1111);
        step(0, 1, 1, 0);
        check("R10 armed clear", flags, 4'b0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule